// File: doc/BRIEF.md
# Transmit Descriptor Chain Walker

This block walks a ring of transmit descriptors held in a small local memory. A host-side port fills the ring entries. The walker finds the next frame and presents each buffer to a byte-stream transmit path as an address plus a byte length. When a buffer is finished, the walker writes the descriptor back in one write. That write clears ownership and records the status of the frame.

A frame can span several chained descriptors. A start flag marks its first buffer and an end flag marks its last. The byte count in each descriptor is stored negated. Two faults are handled:

- **Missing next descriptor.** A chain can run into a descriptor that the host does not own yet. This is reported as a buffer error and an underflow.
- **FIFO underflow.** The downstream path can report that its FIFO ran empty. The current buffer is then cut short.

After either fault, a programmable policy decides what happens next. The transmitter either switches off until a host restart strobe, or it resynchronises on the next owned descriptor that carries the start flag. Two further status flags are collected per frame: a channel-busy deferral flag and a bus parity error flag.

Top module: `txw_chain_walker`

## Requirements
- R1: After reset the transmitter-on output is 1, no buffer is presented, the current ring index is 0 and every descriptor reads as zero.
- R2: Descriptor layout, from bit 38 down to bit 0:
  - [38] owned
  - [37] start
  - [36] end
  - [35] deferred
  - [34] parity error
  - [33] buffer error
  - [32] underflow
  - [31:28] four ones
  - [27:16] 12-bit count
  - [15:0] buffer address

  The presented length is 4096 minus the count, modulo 4096, with a count of zero meaning 4096 bytes.
- R3: While looking for a frame, the walker starts on a descriptor only if it is owned and has the start flag set. It steps past an owned descriptor without the start flag and leaves it untouched. It waits on an unowned descriptor.
- R4: Each presented buffer carries its own start and end flags. When a non-final buffer completes and the next descriptor is owned, the next buffer is presented from the following cycle with no gap. The retired non-final descriptor has its four status flags cleared.
- R5: Retiring a descriptor clears its owned bit in a single write. The start flag, end flag, ones field, count and address are preserved.
- R6: If the channel-busy input is high in any cycle while a frame's buffers are presented, the deferred flag is set in the descriptor that ends the frame.
- R7: The parity error input is recorded into the parity error flag only while parity handling is enabled.
- R8: A non-final buffer that completes while the next descriptor is unowned is retired with both the buffer error flag and the underflow flag set.
- R9: A FIFO underflow while a buffer is presented truncates the frame. That descriptor is retired with the underflow flag set and the buffer error flag clear, and no buffer is presented in the following cycle.
- R10: After a buffer error or an underflow, behaviour depends on the recovery input:
  - Recovery 0: the transmitter-on output drops, and no buffer is presented until a restart strobe sets it again.
  - Recovery 1: the transmitter stays on and resumes at the next owned descriptor with the start flag.
- R11: The ring index advances by one per consumed or skipped descriptor and wraps from the last entry to entry 0.
- R12: A FIFO underflow pulse while no buffer is presented has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host descriptor write strobe |
| host_widx | input | 3 | Ring entry written by the host |
| host_wdesc | input | 39 | Descriptor written by the host |
| host_ridx | input | 3 | Ring entry read by the host |
| host_rdesc | output | 39 | Descriptor read at host_ridx |
| restart | input | 1 | Turns the transmitter back on |
| uflo_recover | input | 1 | 1 resynchronises after a fault, 0 stops |
| par_en | input | 1 | Enables parity error recording |
| chan_busy | input | 1 | Channel busy indication for deferral |
| par_err | input | 1 | Bus parity error during a buffer |
| fifo_uflo | input | 1 | Downstream FIFO underflow pulse |
| buf_done | input | 1 | Downstream consumed the presented buffer |
| buf_valid | output | 1 | A buffer is presented |
| buf_addr | output | 16 | Address of the presented buffer |
| buf_len | output | 13 | Byte length of the presented buffer |
| buf_sof | output | 1 | Presented buffer starts a frame |
| buf_eof | output | 1 | Presented buffer ends a frame |
| tx_on | output | 1 | Transmitter running |
| cur_idx | output | 3 | Current ring index |

## Verification
Single-buffer frames are driven with the following counts:
- The smallest count.
- A typical frame size.
- A count of zero, which must give 4096.
- A count with only the top bit set.

Each of these frames also combines busy and parity inputs with parity handling on or off. This separates a correct negation from an off-by-one and shows that the parity flag is gated.

Further patterns cover the chaining and recovery paths:
- A three-buffer chain shows gapless hand-over and index wrap.
- A stale owned descriptor without the start flag shows skipping apart from stalling.
- An unowned descriptor in mid-chain, tried under both recovery settings, separates resynchronising from stopping.
- Underflow pulses inside and outside a buffer separate truncation from an ignored input.

// File: rtl/txw_pkg.sv
`timescale 1ns/1ps
package txw_pkg;

    localparam int ADDR_W = 16;
    localparam int CNT_W  = 12;
    localparam int LEN_W  = CNT_W + 1;

    typedef struct packed {
        logic              own;
        logic              stp;
        logic              enp;
        logic              def;
        logic              bpe;
        logic              buff;
        logic              uflo;
        logic [3:0]        ones;
        logic [CNT_W-1:0]  bcnt;
        logic [ADDR_W-1:0] addr;
    } txd_t;

    localparam int DESC_W = $bits(txd_t);

    typedef enum logic {
        W_SEEK = 1'b0,
        W_SEND = 1'b1
    } wstate_t;

    // Negated count to byte length; zero count maps to the full 2**CNT_W.
    function automatic logic [LEN_W-1:0] buf_bytes(input logic [CNT_W-1:0] c);
        return LEN_W'(1 << CNT_W) - {1'b0, c};
    endfunction

endpackage

// File: rtl/txw_desc_ram.sv
`timescale 1ns/1ps
module txw_desc_ram
    import txw_pkg::*;
#(
    parameter int RING = 8,
    localparam int IW  = $clog2(RING)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hw_en,
    input  logic [IW-1:0] hw_idx,
    input  txd_t          hw_d,
    input  logic          wb_en,
    input  logic [IW-1:0] wb_idx,
    input  txd_t          wb_d,
    input  logic [IW-1:0] ra_idx,
    output txd_t          ra_d,
    input  logic [IW-1:0] rb_idx,
    output logic          rb_own,
    input  logic [IW-1:0] rh_idx,
    output txd_t          rh_d
);

    txd_t mem [RING];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RING; i++) mem[i] <= '0;
        end else begin
            if (hw_en) mem[hw_idx] <= hw_d;
            // walker writeback is placed last so it wins a same-entry clash
            if (wb_en) mem[wb_idx] <= wb_d;
        end
    end

    assign ra_d   = mem[ra_idx];
    assign rb_own = mem[rb_idx].own;
    assign rh_d   = mem[rh_idx];

    AST_WB_CLEARS_OWN: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> !wb_d.own); // R5
    AST_WB_KEEPS_HOST: assert property (@(posedge clk) disable iff (rst)
        wb_en |-> (wb_d.bcnt == mem[wb_idx].bcnt && wb_d.stp == mem[wb_idx].stp
                   && wb_d.enp == mem[wb_idx].enp && wb_d.addr == mem[wb_idx].addr)); // R5
    AST_BUFF_WITH_UFLO: assert property (@(posedge clk) disable iff (rst)
        (wb_en && wb_d.buff) |-> wb_d.uflo); // R8

endmodule

// File: rtl/txw_walker.sv
`timescale 1ns/1ps
module txw_walker
    import txw_pkg::*;
#(
    parameter int IW = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  txd_t              cur_d,
    input  logic              nxt_own,
    input  logic              restart,
    input  logic              recover,
    input  logic              par_en,
    input  logic              chan_busy,
    input  logic              par_err,
    input  logic              fifo_uflo,
    input  logic              buf_done,
    output logic [IW-1:0]     idx,
    output logic [IW-1:0]     nidx,
    output logic              wb_en,
    output txd_t              wb_d,
    output logic              buf_valid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  buf_len,
    output logic              buf_sof,
    output logic              buf_eof,
    output logic              tx_on
);

    wstate_t st;
    logic    def_q, bpe_q;
    logic    sending, def_now, bpe_now;
    logic    uf, fin, last, chain_ok, berr, err;

    assign sending  = (st == W_SEND);
    assign def_now  = def_q | (sending & chan_busy);
    assign bpe_now  = bpe_q | (sending & par_err & par_en);
    assign uf       = sending & fifo_uflo;
    assign fin      = sending & buf_done & !fifo_uflo;
    assign last     = fin & cur_d.enp;
    assign chain_ok = fin & !cur_d.enp & nxt_own;
    assign berr     = fin & !cur_d.enp & !nxt_own;
    assign err      = uf | berr;
    assign nidx     = idx + 1'b1;

    always_comb begin
        wb_en     = uf | fin;
        wb_d      = cur_d;
        wb_d.own  = 1'b0;
        wb_d.def  = (last | err) & def_now;
        wb_d.bpe  = (last | err) & bpe_now;
        wb_d.buff = berr;
        wb_d.uflo = err;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= W_SEEK;
            idx   <= '0;
            tx_on <= 1'b1;
            def_q <= 1'b0;
            bpe_q <= 1'b0;
        end else begin
            if (restart) tx_on <= 1'b1;
            case (st)
                W_SEEK: begin
                    if (tx_on && cur_d.own) begin
                        if (cur_d.stp) begin
                            st    <= W_SEND;
                            def_q <= 1'b0;
                            bpe_q <= 1'b0;
                        end else begin
                            idx <= nidx;
                        end
                    end
                end
                W_SEND: begin
                    def_q <= def_now;
                    bpe_q <= bpe_now;
                    if (chain_ok) idx <= nidx;
                    if (last || err) begin
                        idx <= nidx;
                        st  <= W_SEEK;
                    end
                    if (err && !recover) tx_on <= 1'b0;
                end
                default: st <= W_SEEK;
            endcase
        end
    end

    assign buf_valid = sending;
    assign buf_addr  = cur_d.addr;
    assign buf_len   = buf_bytes(cur_d.bcnt);
    assign buf_sof   = cur_d.stp;
    assign buf_eof   = cur_d.enp;

    AST_LEN_RANGE: assert property (@(posedge clk) disable iff (rst)
        buf_valid |-> (buf_len != '0 && buf_len <= LEN_W'(1 << CNT_W))); // R2
    AST_STOP_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !tx_on |-> !buf_valid); // R10
    AST_RESTART_ONLY: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_on) |-> $past(restart)); // R10
    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(idx) |-> idx == IW'($past(idx) + 1'b1)); // R11
    AST_UFLO_TRUNC: assert property (@(posedge clk) disable iff (rst)
        (buf_valid && fifo_uflo) |=> !buf_valid); // R9

endmodule

// File: rtl/txw_chain_walker.sv
`timescale 1ns/1ps
module txw_chain_walker
    import txw_pkg::*;
#(
    parameter int RING = 8,
    localparam int IW  = $clog2(RING)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [IW-1:0]     host_widx,
    input  logic [DESC_W-1:0] host_wdesc,
    input  logic [IW-1:0]     host_ridx,
    output logic [DESC_W-1:0] host_rdesc,
    input  logic              restart,
    input  logic              uflo_recover,
    input  logic              par_en,
    input  logic              chan_busy,
    input  logic              par_err,
    input  logic              fifo_uflo,
    input  logic              buf_done,
    output logic              buf_valid,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [LEN_W-1:0]  buf_len,
    output logic              buf_sof,
    output logic              buf_eof,
    output logic              tx_on,
    output logic [IW-1:0]     cur_idx
);

    txd_t          cur_d, wb_d, rh_d;
    logic          nxt_own, wb_en;
    logic [IW-1:0] idx, nidx;

    txw_desc_ram #(.RING(RING)) u_ram (
        .clk    (clk),
        .rst    (rst),
        .hw_en  (host_we),
        .hw_idx (host_widx),
        .hw_d   (txd_t'(host_wdesc)),
        .wb_en  (wb_en),
        .wb_idx (idx),
        .wb_d   (wb_d),
        .ra_idx (idx),
        .ra_d   (cur_d),
        .rb_idx (nidx),
        .rb_own (nxt_own),
        .rh_idx (host_ridx),
        .rh_d   (rh_d)
    );

    txw_walker #(.IW(IW)) u_walk (
        .clk       (clk),
        .rst       (rst),
        .cur_d     (cur_d),
        .nxt_own   (nxt_own),
        .restart   (restart),
        .recover   (uflo_recover),
        .par_en    (par_en),
        .chan_busy (chan_busy),
        .par_err   (par_err),
        .fifo_uflo (fifo_uflo),
        .buf_done  (buf_done),
        .idx       (idx),
        .nidx      (nidx),
        .wb_en     (wb_en),
        .wb_d      (wb_d),
        .buf_valid (buf_valid),
        .buf_addr  (buf_addr),
        .buf_len   (buf_len),
        .buf_sof   (buf_sof),
        .buf_eof   (buf_eof),
        .tx_on     (tx_on)
    );

    assign host_rdesc = rh_d;
    assign cur_idx    = idx;

endmodule

// File: tb/txw_chain_walker_test.sv
`timescale 1ns/1ps
module txw_chain_walker_test;
    import txw_pkg::*;

    localparam int RING = 8;
    localparam int IW   = 3;

    logic              clk = 1'b0, rst = 1'b1;
    logic              host_we = 0, restart = 0, uflo_recover = 0, par_en = 0;
    logic              chan_busy = 0, par_err = 0, fifo_uflo = 0, buf_done = 0;
    logic [IW-1:0]     host_widx = '0, host_ridx = '0;
    logic [DESC_W-1:0] host_wdesc = '0, host_rdesc;
    logic              buf_valid, buf_sof, buf_eof, tx_on;
    logic [ADDR_W-1:0] buf_addr;
    logic [LEN_W-1:0]  buf_len;
    logic [IW-1:0]     cur_idx;

    txw_chain_walker #(.RING(RING)) uut (
        .clk(clk), .rst(rst), .host_we(host_we), .host_widx(host_widx),
        .host_wdesc(host_wdesc), .host_ridx(host_ridx), .host_rdesc(host_rdesc),
        .restart(restart), .uflo_recover(uflo_recover), .par_en(par_en),
        .chan_busy(chan_busy), .par_err(par_err), .fifo_uflo(fifo_uflo),
        .buf_done(buf_done), .buf_valid(buf_valid), .buf_addr(buf_addr),
        .buf_len(buf_len), .buf_sof(buf_sof), .buf_eof(buf_eof),
        .tx_on(tx_on), .cur_idx(cur_idx)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;

    typedef struct packed {
        logic [11:0] c;
        logic [12:0] len;
        logic        busy, par, pen, xdef, xbpe;
    } vec_t;

    localparam vec_t VECS [5] = '{
        '{12'hFFF, 13'd1,    1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
        '{12'hFC4, 13'd60,   1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        '{12'h000, 13'd4096, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1},
        '{12'h800, 13'd2048, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},
        '{12'hA24, 13'd1500, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic txd_t mk(input bit own, input bit stp, input bit enp,
                                input logic [11:0] c, input logic [15:0] a);
        txd_t d = '0;
        d.own = own; d.stp = stp; d.enp = enp;
        d.ones = 4'hF; d.bcnt = c; d.addr = a;
        return d;
    endfunction

    task automatic wr(input int i, input txd_t d);
        @(negedge clk);
        host_we = 1; host_widx = IW'(i); host_wdesc = d;
        @(negedge clk);
        host_we = 0;
    endtask

    task automatic rd(input int i, output txd_t d);
        host_ridx = IW'(i);
        #0.1;
        d = txd_t'(host_rdesc);
    endtask

    task automatic wait_valid(input string req);
        bit ok = 0;
        for (int k = 0; k < 50 && !ok; k++) begin
            @(negedge clk);
            if (buf_valid) ok = 1;
        end
        chk(req, 32'(ok), 32'd1);
    endtask

    task automatic done_pulse(input logic busy, input logic par);
        buf_done = 1; chan_busy = busy; par_err = par;
        @(negedge clk);
        buf_done = 0; chan_busy = 0; par_err = 0;
    endtask

    task automatic summary;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        txd_t d;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_on", 32'(tx_on), 32'd1);
        chk("R1 valid", 32'(buf_valid), 32'd0);
        chk("R1 idx", 32'(cur_idx), 32'd0);
        rd(3, d);
        chk("R1 ram", 32'(d.own), 32'd0);

        // single-buffer frames from the vector table: R2 R5 R6 R7
        uflo_recover = 1;
        for (int i = 0; i < 5; i++) begin
            par_en = VECS[i].pen;
            wr(i, mk(1, 1, 1, VECS[i].c, 16'h0100 + 16'(i)));
            wait_valid("R3 start");
            chk("R2 len", 32'(buf_len), 32'(VECS[i].len));
            chk("R4 sof_eof", 32'({buf_sof, buf_eof}), 32'd3);
            done_pulse(VECS[i].busy, VECS[i].par);
            rd(i, d);
            chk("R5 own", 32'(d.own), 32'd0);
            chk("R5 bcnt", 32'(d.bcnt), 32'(VECS[i].c));
            chk("R5 ones", 32'(d.ones), 32'hF);
            chk("R6 def", 32'(d.def), 32'(VECS[i].xdef));
            chk("R7 bpe", 32'(d.bpe), 32'(VECS[i].xbpe));
        end
        par_en = 0;

        // three-buffer chain at 5,6,7: R4 R11
        wr(7, mk(1, 0, 1, 12'hFF0, 16'h0700));
        wr(6, mk(1, 0, 0, 12'hFFE, 16'h0600));
        wr(5, mk(1, 1, 0, 12'hFFC, 16'h0500));
        wait_valid("R4 chain start");
        chk("R4 first addr", 32'(buf_addr), 32'h0500);
        chk("R4 first flags", 32'({buf_sof, buf_eof}), 32'd2);
        chk("R2 len4", 32'(buf_len), 32'd4);
        done_pulse(1, 0);
        chk("R4 no gap", 32'({buf_valid, buf_addr}), 32'h10600);
        chk("R4 mid flags", 32'({buf_sof, buf_eof}), 32'd0);
        done_pulse(0, 0);
        chk("R4 last addr", 32'({buf_valid, buf_addr}), 32'h10700);
        chk("R4 last flags", 32'({buf_sof, buf_eof}), 32'd1);
        done_pulse(0, 0);
        chk("R11 wrap", 32'(cur_idx), 32'd0);
        rd(5, d);
        chk("R4 first retired", 32'({d.own, d.def, d.bpe, d.buff, d.uflo}), 32'd0);
        rd(7, d);
        chk("R6 def in last", 32'({d.own, d.def}), 32'd1);

        // skip an owned descriptor without the start flag: R3
        wr(1, mk(1, 1, 1, 12'hFF8, 16'h0110));
        wr(0, mk(1, 0, 1, 12'hFF8, 16'h0AAA));
        wait_valid("R3 after skip");
        chk("R3 skip addr", 32'(buf_addr), 32'h0110);
        done_pulse(0, 0);
        rd(0, d);
        chk("R3 skipped untouched", 32'({d.own, d.stp, d.enp}), 32'd5);

        // unowned next, recovery on: R8 R10
        wr(5, mk(1, 1, 1, 12'hFF0, 16'h0550));
        wr(4, mk(1, 0, 1, 12'hFF0, 16'h0440));
        wr(3, mk(0, 0, 1, 12'hFF0, 16'h0330));
        wr(2, mk(1, 1, 0, 12'hFF0, 16'h0220));
        wait_valid("R8 start");
        chk("R8 addr", 32'(buf_addr), 32'h0220);
        done_pulse(0, 0);
        chk("R10 recover valid", 32'(buf_valid), 32'd0);
        chk("R10 recover tx_on", 32'(tx_on), 32'd1);
        rd(2, d);
        chk("R8 flags", 32'({d.own, d.buff, d.uflo}), 32'd3);
        chk("R11 idx", 32'(cur_idx), 32'd3);
        wr(3, mk(1, 0, 1, 12'hFF0, 16'h0330));
        wait_valid("R10 resync");
        chk("R10 resync addr", 32'(buf_addr), 32'h0550);
        done_pulse(0, 0);

        // unowned next, recovery off: R8 R10
        uflo_recover = 0;
        wr(6, mk(1, 1, 0, 12'hFF0, 16'h0660));
        wait_valid("R10 stop start");
        done_pulse(0, 0);
        chk("R10 stopped", 32'(tx_on), 32'd0);
        rd(6, d);
        chk("R8 flags stop", 32'({d.buff, d.uflo}), 32'd3);
        wr(7, mk(1, 1, 1, 12'hFF0, 16'h0770));
        repeat (5) @(negedge clk);
        chk("R10 held off", 32'(buf_valid), 32'd0);
        restart = 1;
        @(negedge clk);
        restart = 0;
        wait_valid("R10 restart");
        chk("R10 restart addr", 32'({tx_on, buf_addr}), 32'h10770);
        done_pulse(0, 0);

        // FIFO underflow in a buffer, recovery on: R9
        uflo_recover = 1;
        wr(1, mk(1, 1, 1, 12'hF00, 16'h0111));
        wait_valid("R9 start");
        fifo_uflo = 1;
        @(negedge clk);
        fifo_uflo = 0;
        chk("R9 truncated", 32'(buf_valid), 32'd0);
        chk("R9 tx_on", 32'(tx_on), 32'd1);
        rd(1, d);
        chk("R9 flags", 32'({d.own, d.buff, d.uflo}), 32'd1);

        // underflow while idle: R12
        uflo_recover = 0;
        fifo_uflo = 1;
        @(negedge clk);
        fifo_uflo = 0;
        @(negedge clk);
        chk("R12 tx_on", 32'(tx_on), 32'd1);
        chk("R12 idx", 32'(cur_idx), 32'd2);

        summary();
        $finish;
    end

endmodule